// File: doc/BRIEF.md
# Multibank DRAM Command Legality Checker

This block sits beside the command bus of a multibank DRAM and inspects one decoded command per clock. It keeps a record of what every bank is doing: activating a row, holding an open row, writing or reading (with or without auto-precharge), or idle. It also keeps a small set of shared turnaround timers. From this record it decides whether the command now on the bus may run in parallel with the actions already under way. Commands it finds illegal are reported and are not applied to its record.

The command is judged in the cycle it appears, and the verdict is registered. The flag and a numeric reason therefore show up one cycle later. Two strobes tell the block that the data burst of the oldest outstanding write or read has finished, and the write or read action ends from there. The per-bank state and a busy bit are always visible, so a controller or a bench can follow the bank bookkeeping directly. All timing limits are cycle-count parameters (`T_RCD` and `T_WR` at least 2, the others at least 1).

Top module: `mbank_cmd_guard`

## Requirements
- R1: While reset is held and after it is released, every bank reads IDLE and not busy, and the violation flag and code are 0.
- R2: The verdict on the command of cycle c appears on `viol_o`/`viol_code_o` in cycle c+1 and lasts one cycle. The flag is high exactly when the code is nonzero, and a NOP (command 0) is never flagged.
- R3: Command encoding is 0 NOP, 1 ACT, 2 PRE, 3 WR, 4 WR with auto-precharge, 5 RD, 6 RD with auto-precharge, 7 reserved. Bank b's state sits at `bank_state_o[3b+2:3b]` and uses 0 IDLE, 1 ACTIVATING, 2 OPEN, 3 WRITING, 4 WRITING_AP, 5 READING, 6 READING_AP. `bank_busy_o[b]` is high for states 1 and 3 to 6.
- R4: An accepted ACT in cycle c makes the bank ACTIVATING from cycle c+1 through c+T_RCD-1 and OPEN from cycle c+T_RCD. An accepted PRE makes the bank IDLE in the next cycle.
- R5: An ACT issued fewer than T_RRD cycles after an accepted ACT to any bank gets code 1.
- R6: A WR/WR-AP to a different bank in the cycle right after an accepted WR/WR-AP gets code 2, and so does a RD/RD-AP right after an accepted RD/RD-AP. With one NOP cycle between them the pair is legal.
- R7: A RD or RD-AP issued fewer than T_WTR cycles after an accepted WR or WR-AP gets code 3.
- R8: A WR or WR-AP issued fewer than T_RTW cycles after an accepted RD or RD-AP gets code 4.
- R9: A RD-AP to a bank while another bank is WRITING_AP gets code 5, even after T_WTR has elapsed.
- R10: Command 7, an ACT to a bank that is not IDLE, a PRE to a bank that is neither IDLE nor OPEN, and any column command to a bank that is not OPEN each get code 6.
- R11: When several rules are broken at once, the smallest code among them is reported.
- R12: A command that is reported leaves every bank state and every turnaround timer as if it had been a NOP.
- R13: A write-done strobe retires the oldest outstanding write burst. That bank leaves its write state T_WR cycles after the strobe cycle, going to OPEN after WR and to IDLE after WR-AP.
- R14: A read-done strobe retires the oldest outstanding read burst, and that bank is OPEN (after RD) or IDLE (after RD-AP) in the next cycle. A strobe with no burst of its direction outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command of this cycle |
| bank_i | input | BW | Bank addressed by the command |
| wr_burst_done_i | input | 1 | Data of the oldest outstanding write burst has finished |
| rd_burst_done_i | input | 1 | Data of the oldest outstanding read burst has finished |
| viol_o | output | 1 | Previous cycle's command broke a rule |
| viol_code_o | output | 3 | Reason for the previous cycle's verdict, 0 when legal |
| bank_busy_o | output | NB | Per-bank action-in-progress bit |
| bank_state_o | output | 3*NB | Per-bank state fields |

## Verification
The hardest situation to reach from the ports is two bursts of the same direction outstanding at once. In that case a single unlabelled strobe must retire the older bank and leave the younger one untouched. The bench gets there by issuing two writes, and separately two reads, to different banks with the single NOP the gap rule demands between them. It then pulses the strobe once, waits out the recovery time and reads both bank fields. The turnaround windows are swept gap by gap across each limit, and deliberately overlapping violations check the reporting priority.

// File: rtl/mbank_cmd_guard.sv
module mbank_cmd_guard #(
  parameter int NB    = 4,
  parameter int BW    = (NB > 1) ? $clog2(NB) : 1,
  parameter int CW    = 4,
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_WR  = 3,
  parameter int T_WTR = 4,
  parameter int T_RTW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      cmd_i,
  input  logic [BW-1:0]   bank_i,
  input  logic            wr_burst_done_i,
  input  logic            rd_burst_done_i,
  output logic            viol_o,
  output logic [2:0]      viol_code_o,
  output logic [NB-1:0]   bank_busy_o,
  output logic [3*NB-1:0] bank_state_o
);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_WR = 3'd3,
                         C_WRA = 3'd4, C_RD = 3'd5, C_RDA = 3'd6, C_RSV = 3'd7;
  localparam logic [2:0] S_IDLE = 3'd0, S_ACTV = 3'd1, S_OPEN = 3'd2, S_WR = 3'd3,
                         S_WRA = 3'd4, S_RD = 3'd5, S_RDA = 3'd6;
  localparam logic [2:0] V_NONE = 3'd0, V_RRD = 3'd1, V_GAP = 3'd2, V_WTR = 3'd3,
                         V_RTW = 3'd4, V_RDA = 3'd5, V_ILL = 3'd6;
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 2);
  localparam logic [CW-1:0] L_WR  = CW'(T_WR - 2);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
  localparam logic [CW-1:0] L_WTR = CW'(T_WTR - 1);
  localparam logic [CW-1:0] L_RTW = CW'(T_RTW - 1);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [BW-1:0] ONE_A = BW'(1);
  localparam logic [BW:0]   ONE_N = (BW+1)'(1);

  logic [2:0]    st [NB];
  logic [NB-1:0] pend;
  logic [CW-1:0] rrd_c, wtr_c, rtw_c;
  logic          prev_wr, prev_rd;
  logic [BW-1:0] prev_bank;
  logic [2:0]    tgt, code;
  logic          is_wr, is_rd, acc, wra_other, wr_ret, rd_ret;
  logic [BW:0]   wr_n, rd_n, wr_age_n, rd_age_n;

  assign tgt   = st[bank_i];
  assign is_wr = (cmd_i == C_WR) || (cmd_i == C_WRA);
  assign is_rd = (cmd_i == C_RD) || (cmd_i == C_RDA);

  always_comb begin
    wr_n = '0;
    rd_n = '0;
    wra_other = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (pend[b] && (st[b] == S_WR || st[b] == S_WRA)) wr_n = wr_n + ONE_N;
      if (pend[b] && (st[b] == S_RD || st[b] == S_RDA)) rd_n = rd_n + ONE_N;
      if (st[b] == S_WRA && BW'(b) != bank_i) wra_other = 1'b1;
    end
  end

  assign wr_ret   = wr_burst_done_i && (wr_n != '0);
  assign rd_ret   = rd_burst_done_i && (rd_n != '0);
  assign wr_age_n = wr_n - {{BW{1'b0}}, wr_ret};
  assign rd_age_n = rd_n - {{BW{1'b0}}, rd_ret};

  always_comb begin
    code = V_NONE;
    if (cmd_i == C_RSV) code = V_ILL;
    else if (cmd_i == C_ACT && tgt != S_IDLE) code = V_ILL;
    else if (cmd_i == C_PRE && tgt != S_IDLE && tgt != S_OPEN) code = V_ILL;
    else if ((is_wr || is_rd) && tgt != S_OPEN) code = V_ILL;
    if (cmd_i == C_RDA && wra_other) code = V_RDA;
    if (is_wr && rtw_c != '0) code = V_RTW;
    if (is_rd && wtr_c != '0) code = V_WTR;
    if (((is_wr && prev_wr) || (is_rd && prev_rd)) && bank_i != prev_bank) code = V_GAP;
    if (cmd_i == C_ACT && rrd_c != '0) code = V_RRD;
  end

  assign acc = (code == V_NONE) && (cmd_i != C_NOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_c <= '0; wtr_c <= '0; rtw_c <= '0;
      prev_wr <= 1'b0; prev_rd <= 1'b0; prev_bank <= '0;
      viol_o <= 1'b0; viol_code_o <= V_NONE;
    end else begin
      rrd_c <= (acc && cmd_i == C_ACT) ? L_RRD : ((rrd_c != '0) ? rrd_c - ONE_C : rrd_c);
      wtr_c <= (acc && is_wr) ? L_WTR : ((wtr_c != '0) ? wtr_c - ONE_C : wtr_c);
      rtw_c <= (acc && is_rd) ? L_RTW : ((rtw_c != '0) ? rtw_c - ONE_C : rtw_c);
      prev_wr   <= acc && is_wr;
      prev_rd   <= acc && is_rd;
      prev_bank <= bank_i;
      viol_o      <= (code != V_NONE);
      viol_code_o <= code;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [2:0]    s;
    logic [CW-1:0] t;
    logic          p;
    logic [BW-1:0] a;
    logic          hit;

    assign hit = acc && (bank_i == BW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        s <= S_IDLE; t <= '0; p <= 1'b0; a <= '0;
      end else if (hit) begin
        case (cmd_i)
          C_ACT: begin s <= S_ACTV; t <= L_RCD; end
          C_PRE: s <= S_IDLE;
          C_WR, C_WRA: begin
            s <= (cmd_i == C_WR) ? S_WR : S_WRA;
            p <= 1'b1;
            a <= wr_age_n[BW-1:0];
          end
          C_RD, C_RDA: begin
            s <= (cmd_i == C_RD) ? S_RD : S_RDA;
            p <= 1'b1;
            a <= rd_age_n[BW-1:0];
          end
          default: ;
        endcase
      end else begin
        case (s)
          S_ACTV: if (t == '0) s <= S_OPEN; else t <= t - ONE_C;
          S_WR, S_WRA: begin
            if (p) begin
              if (wr_burst_done_i) begin
                if (a == '0) begin p <= 1'b0; t <= L_WR; end
                else a <= a - ONE_A;
              end
            end else if (t == '0) s <= (s == S_WR) ? S_OPEN : S_IDLE;
            else t <= t - ONE_C;
          end
          S_RD, S_RDA: begin
            if (p && rd_burst_done_i) begin
              if (a == '0) begin p <= 1'b0; s <= (s == S_RD) ? S_OPEN : S_IDLE; end
              else a <= a - ONE_A;
            end
          end
          default: ;
        endcase
      end
    end

    assign st[g]                = s;
    assign pend[g]              = p;
    assign bank_state_o[3*g +: 3] = s;
    assign bank_busy_o[g]       = (s != S_IDLE) && (s != S_OPEN);
  end
endmodule

module mbank_cmd_guard_sva #(
  parameter int NB    = 4,
  parameter int BW    = 2,
  parameter int T_RRD = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      cmd_i,
  input logic [BW-1:0]   bank_i,
  input logic            viol_o,
  input logic [2:0]      viol_code_o,
  input logic [NB-1:0]   bank_busy_o,
  input logic [3*NB-1:0] bank_state_o
);
  logic          rst_q;
  logic [2:0]    cmd_q, tgt_st, prev_st;
  logic [BW-1:0] bank_q;
  logic          wra_oth, wr_now, wr_was, col_now;

  always_ff @(posedge clk) begin
    rst_q  <= rst;
    cmd_q  <= cmd_i;
    bank_q <= bank_i;
  end

  always_comb begin
    tgt_st  = bank_state_o[3*bank_i +: 3];
    prev_st = bank_state_o[3*bank_q +: 3];
    wra_oth = 1'b0;
    for (int b = 0; b < NB; b++)
      if (bank_state_o[3*b +: 3] == 3'd4 && b != int'(bank_i)) wra_oth = 1'b1;
  end

  assign wr_now  = (cmd_i == 3'd3) || (cmd_i == 3'd4);
  assign wr_was  = (cmd_q == 3'd3) || (cmd_q == 3'd4);
  assign col_now = (cmd_i >= 3'd3) && (cmd_i <= 3'd6);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (bank_busy_o == '0 && bank_state_o == '0 && !viol_o));
  assert_flag_matches_code_R2: assert property (@(posedge clk) disable iff (rst)
    viol_o == (viol_code_o != 3'd0));
  assert_nop_never_flagged_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd0) |=> !viol_o);
  assert_pre_idles_bank_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && cmd_q == 3'd2 && !viol_o) |-> (prev_st == 3'd0));
  assert_act_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    ((T_RRD > 1) && !rst_q && cmd_q == 3'd1 && cmd_i == 3'd1 && !viol_o) |=> (viol_code_o == 3'd1));
  assert_nop_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && wr_now && wr_was && bank_i != bank_q && !viol_o) |=> (viol_code_o == 3'd2));
  assert_rda_during_wra_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd6 && wra_oth) |=> viol_o);
  assert_column_needs_open_R10: assert property (@(posedge clk) disable iff (rst)
    (col_now && tgt_st != 3'd2) |=> viol_o);
endmodule

bind mbank_cmd_guard mbank_cmd_guard_sva #(.NB(NB), .BW(BW), .T_RRD(T_RRD)) u_sva (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .viol_o(viol_o),
  .viol_code_o(viol_code_o), .bank_busy_o(bank_busy_o), .bank_state_o(bank_state_o)
);

// File: tb/mbank_cmd_guard_tb.sv
module mbank_cmd_guard_tb;
  localparam int NB = 4, BW = 2, T_RCD = 3, T_RRD = 2, T_WR = 3, T_WTR = 4, T_RTW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [BW-1:0] bank = '0;
  logic wd = 1'b0, rdn = 1'b0;
  logic viol;
  logic [2:0] code;
  logic [NB-1:0] busy;
  logic [3*NB-1:0] sts;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbank_cmd_guard #(.NB(NB), .BW(BW), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_WR(T_WR),
                    .T_WTR(T_WTR), .T_RTW(T_RTW)) u_dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .wr_burst_done_i(wd),
    .rd_burst_done_i(rdn), .viol_o(viol), .viol_code_o(code), .bank_busy_o(busy),
    .bank_state_o(sts));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int c, input int b, input bit w, input bit r);
    @(negedge clk);
    cmd = 3'(c); bank = BW'(b); wd = w; rdn = r;
    @(posedge clk);
    #1;
    cmd = 3'd0; wd = 1'b0; rdn = 1'b0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1'b0, 1'b0);
  endtask

  function automatic int bst(input int b);
    return int'(sts[3*b +: 3]);
  endfunction

  task automatic verdict(input string tag, input int exp);
    check({tag, " code"}, int'(code), exp);
    check({tag, " flag"}, int'(viol), int'(exp != 0));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic open_all();
    do_reset();
    for (int b = 0; b < NB; b++) begin
      step(1, b, 1'b0, 1'b0);
      nop(T_RRD - 1);
    end
    nop(T_RCD);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1 busy after reset", int'(busy), 0);
    check("R1 states after reset", int'(sts), 0);
    check("R1 flag after reset", int'(viol), 0);

    for (int b = 0; b < NB; b++) begin
      do_reset();
      step(1, b, 1'b0, 1'b0);
      verdict("R2 legal ACT", 0);
      check("R3 ACTIVATING code", bst(b), 1);
      check("R3 busy while activating", int'(busy[b]), 1);
      nop(T_RCD - 2);
      check("R4 still activating", bst(b), 1);
      nop(1);
      check("R4 open after T_RCD", bst(b), 2);
      check("R3 open not busy", int'(busy[b]), 0);
    end

    do_reset();
    step(1, 0, 1'b0, 1'b0);
    nop(T_RCD - 2);
    step(3, 0, 1'b0, 1'b0);
    verdict("R4 WR one cycle early", 6);
    check("R12 early WR not applied", bst(0), 2);
    nop(1);
    check("R2 flag clears after NOP", int'(viol), 0);

    for (int g = 1; g <= T_RRD + 1; g++) begin
      do_reset();
      step(1, 0, 1'b0, 1'b0);
      nop(g - 1);
      step(1, 1, 1'b0, 1'b0);
      verdict($sformatf("R5 ACT gap %0d", g), (g < T_RRD) ? 1 : 0);
    end

    for (int g = 1; g <= T_WTR + 1; g++) begin
      open_all();
      step(3, 0, 1'b0, 1'b0);
      nop(g - 1);
      step(5, 1, 1'b0, 1'b0);
      verdict($sformatf("R7 WR-RD gap %0d", g), (g < T_WTR) ? 3 : 0);
    end

    for (int g = 1; g <= T_RTW + 1; g++) begin
      open_all();
      step(5, 0, 1'b0, 1'b0);
      nop(g - 1);
      step(3, 1, 1'b0, 1'b0);
      verdict($sformatf("R8 RD-WR gap %0d", g), (g < T_RTW) ? 4 : 0);
    end

    open_all();
    step(3, 0, 1'b0, 1'b0);
    step(4, 1, 1'b0, 1'b0);
    verdict("R6 back-to-back writes", 2);
    check("R12 rejected write left bank open", bst(1), 2);
    open_all();
    step(3, 0, 1'b0, 1'b0);
    nop(1);
    step(3, 1, 1'b0, 1'b0);
    verdict("R6 writes with NOP", 0);
    open_all();
    step(5, 0, 1'b0, 1'b0);
    step(6, 1, 1'b0, 1'b0);
    verdict("R6 back-to-back reads", 2);
    open_all();
    step(5, 0, 1'b0, 1'b0);
    nop(1);
    step(5, 1, 1'b0, 1'b0);
    verdict("R6 reads with NOP", 0);

    open_all();
    step(4, 0, 1'b0, 1'b0);
    nop(T_WTR - 1);
    step(6, 1, 1'b0, 1'b0);
    verdict("R9 RDA during WRA", 5);
    step(5, 1, 1'b0, 1'b0);
    verdict("R9 plain RD during WRA", 0);
    check("R3 READING code", bst(1), 5);

    open_all();
    step(4, 0, 1'b0, 1'b0);
    step(6, 1, 1'b0, 1'b0);
    verdict("R11 tWTR beats RDA rule", 3);
    do_reset();
    step(1, 0, 1'b0, 1'b0);
    step(1, 0, 1'b0, 1'b0);
    verdict("R11 tRRD beats illegal", 1);

    open_all();
    step(7, 0, 1'b0, 1'b0);
    verdict("R10 reserved command", 6);
    nop(T_RRD);
    step(1, 0, 1'b0, 1'b0);
    verdict("R10 ACT to open bank", 6);
    check("R12 rejected ACT left bank open", bst(0), 2);
    do_reset();
    step(1, 0, 1'b0, 1'b0);
    step(2, 0, 1'b0, 1'b0);
    verdict("R10 PRE while activating", 6);
    do_reset();
    step(5, 1, 1'b0, 1'b0);
    verdict("R10 RD to idle bank", 6);

    open_all();
    step(2, 2, 1'b0, 1'b0);
    verdict("R4 PRE accepted", 0);
    check("R4 PRE idles bank", bst(2), 0);
    step(3, 2, 1'b0, 1'b0);
    verdict("R10 WR to idle bank", 6);
    step(5, 1, 1'b0, 1'b0);
    verdict("R12 rejected WR started no tWTR", 0);

    open_all();
    step(4, 0, 1'b0, 1'b0);
    check("R3 WRITING_AP code", bst(0), 4);
    nop(2);
    step(0, 0, 1'b1, 1'b0);
    nop(T_WR - 2);
    check("R13 WRA still in recovery", bst(0), 4);
    nop(1);
    check("R13 WRA ends idle", bst(0), 0);

    open_all();
    step(3, 0, 1'b0, 1'b0);
    nop(1);
    step(3, 1, 1'b0, 1'b0);
    step(0, 0, 1'b1, 1'b0);
    nop(T_WR - 1);
    check("R13 oldest write retired", bst(0), 2);
    check("R13 younger write still writing", bst(1), 3);
    step(0, 0, 1'b1, 1'b0);
    nop(T_WR - 1);
    check("R13 second write retired", bst(1), 2);

    open_all();
    step(5, 0, 1'b0, 1'b0);
    nop(1);
    step(6, 1, 1'b0, 1'b0);
    check("R3 READING_AP code", bst(1), 6);
    step(0, 0, 1'b0, 1'b1);
    check("R14 oldest read retired", bst(0), 2);
    check("R14 younger read outstanding", bst(1), 6);
    step(0, 0, 1'b0, 1'b1);
    check("R14 RDA ends idle", bst(1), 0);
    step(0, 0, 1'b1, 1'b1);
    check("R14 stray strobes ignored", int'(sts), 2 | (0 << 3) | (2 << 6) | (2 << 9));
    check("R14 stray strobes no flag", int'(viol), 0);

    done = 1'b1;
    summary();
  end
endmodule